// File: doc/BRIEF.md
# Slotted Display Memory Arbiter

This block shares one single-port display memory between a screen refresh fetcher and a CPU bus interface. Memory time is cut into slots of a fixed number of clocks. The owner of each slot is fixed at its boundary. The refresh fetcher always wins any slot it may claim. The CPU gets only the slots the fetcher leaves free. A CPU request that arrives part way through a slot waits for the next boundary, even when the memory is idle.

While a CPU read or write is outstanding, the block holds the CPU ready line low, so the CPU inserts wait states. The CPU samples ready in the third clock of its four-clock bus cycle. Ready returns high in the clock after the CPU's slot ends. The number of wait states therefore depends only on the slot phase and on how busy the fetcher is.

The memory is synchronous. A read issued in one clock returns its data in the next clock and holds that data until the next read. The CPU clock and the slot clock are one domain. `SLOT_CLKS` gives the slot length and must be at least 2. `VID_SLOTS` of every `PATTERN_LEN` slots may be claimed by the fetcher.

Top module: `dispmem_slot_arb`

## Requirements
- R1: When the fetcher requests a claimable slot, it owns that slot whether or not a CPU access is pending. `vid_gnt` pulses in the slot's first clock, together with the memory access at the fetcher's address.
- R2: `mem_en` is high only in the first clock of a slot. Slots start every `SLOT_CLKS` clocks, counted from the first clock after reset. A CPU request accepted part way through a slot is not served before the next slot boundary.
- R3: Slots are numbered 0 to `PATTERN_LEN-1` from reset and the count wraps. Only slots numbered below `VID_SLOTS` can be claimed by the fetcher. Every other slot goes to a pending CPU access, or stays idle if none is pending.
- R4: `cpu_ready` is high while no CPU access is pending. It goes low in the clock after a request is accepted. It returns high in the clock after the last clock of the slot that served the access.
- R5: For a CPU read, `cpu_rdata` takes the memory word in the second clock of the CPU's slot. It holds that value until the next CPU read, and so it is stable whenever `cpu_ready` stays high.
- R6: A `cpu_req` pulse while an access is pending is ignored. Writes wait for a free slot in the same way as reads, and drive `mem_we` with the captured address and data.
- R7: During reset and in the first clock after it, `cpu_ready` is high and `mem_en`, `vid_gnt` and `vid_rvalid` are low.
- R8: `vid_rvalid` is high in the clock after `vid_gnt`, with `vid_rdata` holding the fetched word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the CPU bus and the slot timer |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-clock pulse that starts a CPU bus access |
| cpu_we | input | 1 | 1 = write, 0 = read, taken with `cpu_req` |
| cpu_addr | input | AW | CPU word address, taken with `cpu_req` |
| cpu_wdata | input | DW | CPU write data, taken with `cpu_req` |
| cpu_ready | output | 1 | Low while a CPU access is pending (wait states) |
| cpu_rdata | output | DW | Latched CPU read data |
| vid_req | input | 1 | Fetcher wants the next slot |
| vid_addr | input | AW | Fetcher address, taken at the slot boundary |
| vid_gnt | output | 1 | Fetcher owns the slot that starts in this clock |
| vid_rvalid | output | 1 | `vid_rdata` is valid |
| vid_rdata | output | DW | Fetched word |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the clock after the read |

## Verification
The contested case is a slot boundary at which a CPU access is pending and the fetcher is also requesting. It is provoked by holding `vid_req` high through whole patterns and by toggling it at random while CPU accesses start at random slot phases. At every clock, the bench compares the ready line, the grant, the memory strobe, the address and the data against a slot-count reference. The outcome is judged by which requester appears on the memory port and by when ready rises.

// File: rtl/dispmem_slot_arb.sv
module dispmem_slot_arb #(
  parameter int AW          = 12,
  parameter int DW          = 8,
  parameter int SLOT_CLKS   = 4,
  parameter int PATTERN_LEN = 10,
  parameter int VID_SLOTS   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  input  logic          vid_req,
  input  logic [AW-1:0] vid_addr,
  output logic          vid_gnt,
  output logic          vid_rvalid,
  output logic [DW-1:0] vid_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam int SW = (PATTERN_LEN > 1) ? $clog2(PATTERN_LEN) : 1;

  typedef enum logic [1:0] {OWN_NONE, OWN_VID, OWN_CPU} own_t;

  logic [PW-1:0] phase;
  logic [SW-1:0] slot;
  own_t          own;
  logic          pend, c_we;
  logic [AW-1:0] c_addr, v_addr;
  logic [DW-1:0] c_wd, c_rd;

  wire           slot_end = (phase == PW'(SLOT_CLKS - 1));
  wire           slot_beg = (phase == '0);
  wire [SW-1:0]  nslot    = (slot == SW'(PATTERN_LEN - 1)) ? '0 : slot + 1'b1;
  wire           vid_ok   = vid_req && (32'(nslot) < VID_SLOTS);
  wire           cpu_ok   = pend && (own != OWN_CPU);
  wire           cpu_done = slot_end && (own == OWN_CPU);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      slot   <= '0;
      own    <= OWN_NONE;
      pend   <= 1'b0;
      c_we   <= 1'b0;
      c_addr <= '0;
      c_wd   <= '0;
      v_addr <= '0;
      c_rd   <= '0;
    end else begin
      phase <= slot_end ? '0 : phase + 1'b1;
      if (slot_end) begin
        slot <= nslot;
        if (vid_ok) begin
          own    <= OWN_VID;
          v_addr <= vid_addr;
        end else if (cpu_ok) begin
          own <= OWN_CPU;
        end else begin
          own <= OWN_NONE;
        end
      end
      if (cpu_req && !pend) begin
        pend   <= 1'b1;
        c_we   <= cpu_we;
        c_addr <= cpu_addr;
        c_wd   <= cpu_wdata;
      end else if (cpu_done) begin
        pend <= 1'b0;
      end
      if (phase == PW'(1) && own == OWN_CPU && !c_we)
        c_rd <= mem_rdata;
    end
  end

  assign cpu_ready  = !pend;
  assign cpu_rdata  = c_rd;
  assign vid_gnt    = slot_beg && (own == OWN_VID);
  assign vid_rvalid = (phase == PW'(1)) && (own == OWN_VID);
  assign vid_rdata  = mem_rdata;
  assign mem_en     = slot_beg && (own != OWN_NONE);
  assign mem_we     = mem_en && (own == OWN_CPU) && c_we;
  assign mem_addr   = (own == OWN_VID) ? v_addr : c_addr;
  assign mem_wdata  = c_wd;

  // R4
  accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_ready |=> !cpu_ready);

  // R4
  release_after_cpu_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ready) |-> $past(own == OWN_CPU) && $past(slot_end));

  // R2
  spaced_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> !mem_en);

  // R8
  fetch_data_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_gnt |=> vid_rvalid);

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && $past(cpu_ready) |-> $stable(cpu_rdata));

  // R1
  fetch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_gnt |-> !mem_we);
endmodule

// File: tb/tb_dispmem_slot_arb.sv
`timescale 1ns/1ps
module tb_dispmem_slot_arb;
  localparam int AW = 12, DW = 8, S = 4, P = 10, V = 9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, cpu_req, cpu_we, vid_req;
  logic [AW-1:0] cpu_addr, vid_addr, mem_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, vid_rdata, mem_wdata, mem_rdata;
  logic          cpu_ready, vid_gnt, vid_rvalid, mem_en, mem_we;

  dispmem_slot_arb #(.AW(AW), .DW(DW), .SLOT_CLKS(S), .PATTERN_LEN(P), .VID_SLOTS(V)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .vid_req(vid_req),
    .vid_addr(vid_addr), .vid_gnt(vid_gnt), .vid_rvalid(vid_rvalid), .vid_rdata(vid_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  logic [DW-1:0] ram [16];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) ram[i] <= DW'(i * 17 + 3);
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) ram[mem_addr[3:0]] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr[3:0]];
    end
  end

  int vectors = 0, errors = 0;
  int cyc, m_pend, m_we, m_own;
  logic [AW-1:0] m_addr, m_vaddr;
  logic [DW-1:0] m_wd, m_rd;
  logic [DW-1:0] shadow [16];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  // Entered at a negedge: compare, drive, advance model, move to next negedge.
  task automatic step(input logic rq, input logic we, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input logic vr, input logic [AW-1:0] va);
    int ph, nidx, nown;
    logic en;
    ph = cyc % S;
    en = (ph == 0) && (m_own != 0);
    chk("R4 cpu_ready", 32'(cpu_ready), 32'(m_pend == 0));
    chk("R2 mem_en", 32'(mem_en), 32'(en));
    if (en) begin
      chk("R1/R3 mem_addr", 32'(mem_addr), 32'((m_own == 1) ? m_vaddr : m_addr));
      chk("R6 mem_we", 32'(mem_we), 32'(m_own == 2 && m_we == 1));
      if (m_own == 2 && m_we == 1) chk("R6 mem_wdata", 32'(mem_wdata), 32'(m_wd));
    end
    chk("R1 vid_gnt", 32'(vid_gnt), 32'(ph == 0 && m_own == 1));
    chk("R8 vid_rvalid", 32'(vid_rvalid), 32'(ph == 1 && m_own == 1));
    if (ph == 1 && m_own == 1) chk("R8 vid_rdata", 32'(vid_rdata), 32'(shadow[m_vaddr[3:0]]));
    chk("R5 cpu_rdata", 32'(cpu_rdata), 32'(m_rd));
    cpu_req = rq; cpu_we = we; cpu_addr = a; cpu_wdata = wd; vid_req = vr; vid_addr = va;
    #1;
    nidx = ((cyc / S) + 1) % P;
    nown = m_own;
    if (ph == 0 && m_own == 2 && m_we == 1) shadow[m_addr[3:0]] = m_wd;
    if (ph == 1 && m_own == 2 && m_we == 0) m_rd = shadow[m_addr[3:0]];
    if (ph == S - 1) begin
      if (vr && nidx < V) begin nown = 1; m_vaddr = va; end
      else if (m_pend == 1 && m_own != 2) nown = 2;
      else nown = 0;
    end
    if (rq && m_pend == 0) begin
      m_pend = 1; m_we = int'(we); m_addr = a; m_wd = wd;
    end else if (ph == S - 1 && m_own == 2) begin
      m_pend = 0;
    end
    m_own = nown;
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  function automatic logic vid_pick(input int mode);
    return (mode == 1) || (mode == 2 && ($urandom % 3 != 0));
  endfunction

  task automatic idle(input int n, input int mode);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, vid_pick(mode), AW'($urandom % 16));
  endtask

  // One CPU bus access; dbl issues an extra request while pending (R6: ignored).
  task automatic cpu_op(input logic we, input logic [3:0] a, input logic [DW-1:0] wd,
                        input int mode, input bit dbl);
    step(1'b1, we, AW'(a), wd, vid_pick(mode), AW'($urandom % 16));
    if (dbl) step(1'b1, ~we, AW'(a ^ 4'h5), ~wd, vid_pick(mode), AW'($urandom % 16));
    for (int i = 0; i < 400; i++) begin
      if (cpu_ready) break;
      step(1'b0, 1'b0, '0, '0, vid_pick(mode), AW'($urandom % 16));
    end
    chk("R4 access completes", 32'(cpu_ready), 32'd1);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired (cycle %0d)", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    vid_req = 0; vid_addr = '0;
    cyc = 0; m_pend = 0; m_we = 0; m_own = 0; m_addr = '0; m_vaddr = '0; m_wd = '0; m_rd = '0;
    for (int i = 0; i < 16; i++) shadow[i] = DW'(i * 17 + 3);
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    chk("R7 cpu_ready", 32'(cpu_ready), 32'd1);
    chk("R7 mem_en", 32'(mem_en), 32'd0);
    chk("R7 vid_gnt", 32'(vid_gnt), 32'd0);
    chk("R7 vid_rvalid", 32'(vid_rvalid), 32'd0);
    rst_n = 1'b1;
    // R2: idle memory, requests at every phase still wait for a boundary
    for (int k = 0; k < 8; k++) begin
      idle(k % S, 0);
      cpu_op(1'b1, 4'(k), DW'(8'hA0 + k), 0, 1'b0);
    end
    for (int k = 0; k < 8; k++) begin
      idle((k + 1) % S, 0);
      cpu_op(1'b0, 4'(k), '0, 0, 1'b0);
    end
    // R6: extra request while pending is ignored
    cpu_op(1'b1, 4'd9, 8'h5C, 0, 1'b1);
    cpu_op(1'b0, 4'd9, '0, 0, 1'b0);
    cpu_op(1'b0, 4'd12, '0, 0, 1'b1);
    // R1, R3: fetcher requests every slot; CPU only gets the unclaimable ones
    for (int k = 0; k < 6; k++) begin
      idle(k, 1);
      cpu_op(k[0], 4'(k + 3), DW'(8'h30 + k), 1, 1'b0);
    end
    // R1, R5, R8: mixed traffic with random fetcher demand
    for (int k = 0; k < 60; k++) begin
      idle($urandom % 7, 2);
      cpu_op(1'($urandom), 4'($urandom), DW'($urandom), 2, ($urandom % 5) == 0);
    end
    idle(3 * S * P, 2);
    finish_run();
  end
endmodule